// File: doc/BRIEF.md
# Program ROM Bank Address Mapper

This block turns a CPU address into a program ROM bank number for a cartridge-style memory system. Addresses 8000h-FFFFh always map ROM. The 6000h-7FFFh window maps either ROM or work RAM. Four 8-bit bank registers and one 8-bit mode register hold the configuration. The mode sets the bank size for the upper half: one 32 KiB bank, two 16 KiB banks, four 8 KiB banks, or four 8 KiB banks whose numbers are bit-reversed.

A pair of outer masks, an AND and an OR byte, limits every ROM bank the block produces. This lets one such device serve one game inside a larger multi-game ROM. The masks are shifted right to match the bank size in use.

Register writes take effect on the clock edge. Every output is combinational from the stored registers, the masks and the address. The ROM, the RAM and the bus timing sit outside the block.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset every register holds 0. The block is then in 32 KiB layout with a fixed last bank of FFh, and the 6000h window selects work RAM.
- R2: While `bank_we` is high, a clock edge stores `bank_wdata` into bank register `bank_sel` (0..3). While `mode_we` is high, a clock edge stores `mode_wdata` into the mode register. Both writes may happen in the same cycle.
- R3: The last-bank value is bank register 3 when mode bit 2 is 1. It is FFh when mode bit 2 is 0.
- R4: With mode[1:0]=0, every address in 8000h-FFFFh gives (last & (AND>>2)) | (OR>>2), and `prg_gran` is 0 (32 KiB).
- R5: With mode[1:0]=1, 8000h-BFFFh uses register 1 and C000h-FFFFh uses the last-bank value. Each is masked as (v & (AND>>1)) | (OR>>1), and `prg_gran` is 1 (16 KiB).
- R6: With mode[1:0]=2, the 8 KiB slots at 8000h, A000h and C000h use registers 0, 1 and 2, and E000h uses the last-bank value. Each is masked as (v & AND) | OR, and `prg_gran` is 2 (8 KiB).
- R7: With mode[1:0]=3, the slots pick the same sources as R6. Each value is first bit-reversed over bits 6..0 (bit i moves to bit 6-i, so bit 3 stays in place) and bit 7 is cleared. The result is then masked with the unshifted AND and OR.
- R8: When mode bit 7 is 1, the 6000h-7FFFh window selects ROM (`rom_sel`=1, `prg_gran`=2). Its bank is (w & AND) | OR, where w depends on the layout: {reg3[5:0],2'b11} for layout 0, {reg3[6:0],1'b1} for layout 1, reg3 for layout 2, and reversed reg3 for layout 3.
- R9: When mode bit 7 is 0, the window selects work RAM (`ram_sel`=1, bank 0) if `HAS_WORK_RAM` is 1. If it is 0, the window selects nothing. `rom_sel` and `ram_sel` are never both 1.
- R10: An address below 6000h drives `rom_sel`=0, `ram_sel`=0, `prg_bank`=0 and `prg_gran`=2.
- R11: The outputs depend combinationally on address, masks and registers. A write is visible from the cycle after its clock edge, and outputs hold while nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Bank register write strobe |
| bank_sel | input | 2 | Bank register index for a write |
| bank_wdata | input | 8 | Bank register write data |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| outer_and | input | 8 | Outer AND mask |
| outer_or | input | 8 | Outer OR mask |
| cpu_addr | input | 16 | CPU address |
| prg_bank | output | 8 | Bank number at the granularity given by prg_gran |
| prg_gran | output | 2 | 0 = 32 KiB, 1 = 16 KiB, 2 = 8 KiB |
| rom_sel | output | 1 | The address maps program ROM |
| ram_sel | output | 1 | The address maps work RAM bank 0 |

## Verification
Two things can happen in the same cycle: a register write and a lookup that reads that register. A mode write and a bank write can also land together. The bench provokes both on purpose. It reads 8000h in 16 KiB layout while writing register 1, and it changes the layout and register 3 on the same edge while reading E000h and the 6000h window. The reference model expects the old mapping before the edge and the new mapping in the cycle after it. Random stimulus then mixes writes, mask changes and addresses on every cycle.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int NUM_BANK_REGS = 4;
    localparam int REG_W         = 8;

    typedef enum logic [1:0] {
        LAY_32K    = 2'd0,
        LAY_16K    = 2'd1,
        LAY_8K     = 2'd2,
        LAY_8K_REV = 2'd3
    } layout_e;

    typedef enum logic [1:0] {
        GRAN_32K = 2'd0,
        GRAN_16K = 2'd1,
        GRAN_8K  = 2'd2
    } gran_e;

    typedef struct packed {
        logic [REG_W-1:0]                    mode;
        logic [NUM_BANK_REGS-1:0][REG_W-1:0] bank;
    } map_regs_t;

    // Mirror bits 6..0 about bit 3; bit 7 is dropped.
    function automatic logic [REG_W-1:0] rev7(input logic [REG_W-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        for (int i = 0; i < 7; i++) r[6-i] = v[i];
        return r;
    endfunction

endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
    import prg_map_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bank_we,
    input  logic [$clog2(NUM_BANK_REGS)-1:0] bank_sel,
    input  logic [REG_W-1:0]                 bank_wdata,
    input  logic                             mode_we,
    input  logic [REG_W-1:0]                 mode_wdata,
    output map_regs_t                        regs
);

    map_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bank_we) regs_d.bank[bank_sel] = bank_wdata;
        if (mode_we) regs_d.mode = mode_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

endmodule

// File: rtl/prg_slot_calc.sv
module prg_slot_calc
    import prg_map_pkg::*;
(
    input  map_regs_t                       regs,
    input  logic [REG_W-1:0]                and_mask,
    input  logic [REG_W-1:0]                or_mask,
    output logic [NUM_BANK_REGS-1:0][REG_W-1:0] slot_bank,
    output logic [REG_W-1:0]                win_bank,
    output gran_e                           upper_gran
);

    localparam int LAST = NUM_BANK_REGS - 1;

    layout_e          layout;
    logic [REG_W-1:0] last_v;
    logic [1:0]       shift_d;
    logic [REG_W-1:0] and_sh, or_sh;
    logic [REG_W-1:0] win_raw;

    assign layout = layout_e'(regs.mode[1:0]);
    assign last_v = regs.mode[2] ? regs.bank[LAST] : '1;

    always_comb begin
        case (layout)
            LAY_32K: begin shift_d = 2'd2; upper_gran = GRAN_32K; end
            LAY_16K: begin shift_d = 2'd1; upper_gran = GRAN_16K; end
            default: begin shift_d = 2'd0; upper_gran = GRAN_8K;  end
        endcase
        and_sh = and_mask >> shift_d;
        or_sh  = or_mask  >> shift_d;
    end

    for (genvar s = 0; s < NUM_BANK_REGS; s++) begin : g_slot
        logic [REG_W-1:0] src, picked;
        always_comb begin
            case (layout)
                LAY_32K: src = last_v;
                LAY_16K: src = (s < 2) ? regs.bank[1] : last_v;
                default: src = (s < LAST) ? regs.bank[s] : last_v;
            endcase
            picked       = (layout == LAY_8K_REV) ? rev7(src) : src;
            slot_bank[s] = (picked & and_sh) | or_sh;
        end
    end

    always_comb begin
        case (layout)
            LAY_32K: win_raw = {regs.bank[LAST][5:0], 2'b11};
            LAY_16K: win_raw = {regs.bank[LAST][6:0], 1'b1};
            LAY_8K:  win_raw = regs.bank[LAST];
            default: win_raw = rev7(regs.bank[LAST]);
        endcase
        win_bank = (win_raw & and_mask) | or_mask;
    end

endmodule

// File: rtl/prg_addr_decode.sv
module prg_addr_decode
    import prg_map_pkg::*;
#(
    parameter bit HAS_WORK_RAM = 1'b1
) (
    input  logic [15:0]                         cpu_addr,
    input  logic                                win_rom_en,
    input  logic [NUM_BANK_REGS-1:0][REG_W-1:0] slot_bank,
    input  logic [REG_W-1:0]                    win_bank,
    input  gran_e                               upper_gran,
    output logic [REG_W-1:0]                    prg_bank,
    output gran_e                               prg_gran,
    output logic                                rom_sel,
    output logic                                ram_sel
);

    localparam logic [2:0] WIN_REGION = 3'b011;

    always_comb begin
        prg_bank = '0;
        prg_gran = GRAN_8K;
        rom_sel  = 1'b0;
        ram_sel  = 1'b0;
        if (cpu_addr[15]) begin
            prg_bank = slot_bank[cpu_addr[14:13]];
            prg_gran = upper_gran;
            rom_sel  = 1'b1;
        end else if (cpu_addr[15:13] == WIN_REGION) begin
            if (win_rom_en) begin
                prg_bank = win_bank;
                rom_sel  = 1'b1;
            end else begin
                ram_sel  = HAS_WORK_RAM;
            end
        end
    end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter bit HAS_WORK_RAM = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bank_we,
    input  logic [1:0]  bank_sel,
    input  logic [7:0]  bank_wdata,
    input  logic        mode_we,
    input  logic [7:0]  mode_wdata,
    input  logic [7:0]  outer_and,
    input  logic [7:0]  outer_or,
    input  logic [15:0] cpu_addr,
    output logic [7:0]  prg_bank,
    output logic [1:0]  prg_gran,
    output logic        rom_sel,
    output logic        ram_sel
);

    map_regs_t                           regs;
    logic [NUM_BANK_REGS-1:0][REG_W-1:0] slot_bank;
    logic [REG_W-1:0]                    win_bank;
    gran_e                               upper_gran;
    gran_e                               gran_out;

    prg_map_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_we    (bank_we),
        .bank_sel   (bank_sel),
        .bank_wdata (bank_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .regs       (regs)
    );

    prg_slot_calc u_calc (
        .regs       (regs),
        .and_mask   (outer_and),
        .or_mask    (outer_or),
        .slot_bank  (slot_bank),
        .win_bank   (win_bank),
        .upper_gran (upper_gran)
    );

    prg_addr_decode #(.HAS_WORK_RAM(HAS_WORK_RAM)) u_dec (
        .cpu_addr   (cpu_addr),
        .win_rom_en (regs.mode[7]),
        .slot_bank  (slot_bank),
        .win_bank   (win_bank),
        .upper_gran (upper_gran),
        .prg_bank   (prg_bank),
        .prg_gran   (gran_out),
        .rom_sel    (rom_sel),
        .ram_sel    (ram_sel)
    );

    assign prg_gran = gran_out;

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bank_we,
    input logic        mode_we,
    input logic [7:0]  outer_and,
    input logic [7:0]  outer_or,
    input logic [15:0] cpu_addr,
    input logic [7:0]  prg_bank,
    input logic [1:0]  prg_gran,
    input logic        rom_sel,
    input logic        ram_sel
);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R9: ROM and RAM never selected together
    assert_sel_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel));

    // R9: a RAM selection always reports bank 0
    assert_ram_bank0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> (prg_bank == 8'h00));

    // R10: addresses below the window select nothing
    assert_low_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!rom_sel && !ram_sel && prg_bank == 8'h00));

    // R4: the upper half always maps ROM with a legal granularity
    assert_upper_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15] |-> (rom_sel && prg_gran != 2'd3));

    // R11: with no write and steady inputs, the bank output holds
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(bank_we) && !$past(mode_we) && $stable(cpu_addr)
         && $stable(outer_and) && $stable(outer_or))
        |-> ($stable(prg_bank) && $stable(rom_sel) && $stable(ram_sel)));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_we   (bank_we),
    .mode_we   (mode_we),
    .outer_and (outer_and),
    .outer_or  (outer_or),
    .cpu_addr  (cpu_addr),
    .prg_bank  (prg_bank),
    .prg_gran  (prg_gran),
    .rom_sel   (rom_sel),
    .ram_sel   (ram_sel)
);

// File: tb/prg_bank_mapper_tb.sv
`timescale 1ns/1ps
module prg_bank_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_we = 1'b0;
    logic [1:0]  bank_sel = '0;
    logic [7:0]  bank_wdata = '0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic [7:0]  outer_and = 8'hFF;
    logic [7:0]  outer_or = 8'h00;
    logic [15:0] cpu_addr = 16'h8000;
    logic [7:0]  prg_bank, nr_bank;
    logic [1:0]  prg_gran, nr_gran;
    logic        rom_sel, ram_sel, nr_rom, nr_ram;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    int m_bank[4];
    int m_mode;

    always #2.5 clk = ~clk;

    prg_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_sel(bank_sel),
        .bank_wdata(bank_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .outer_and(outer_and), .outer_or(outer_or), .cpu_addr(cpu_addr),
        .prg_bank(prg_bank), .prg_gran(prg_gran), .rom_sel(rom_sel), .ram_sel(ram_sel)
    );

    prg_bank_mapper #(.HAS_WORK_RAM(1'b0)) u_dut_noram (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_sel(bank_sel),
        .bank_wdata(bank_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .outer_and(outer_and), .outer_or(outer_or), .cpu_addr(cpu_addr),
        .prg_bank(nr_bank), .prg_gran(nr_gran), .rom_sel(nr_rom), .ram_sel(nr_ram)
    );

    function automatic int flip(input int v);
        int r = 0;
        for (int i = 0; i <= 6; i++) if (((v / (1 << i)) % 2) == 1) r += 64 / (1 << i);
        return r;
    endfunction

    // Expected {bank, gran, rom, ram} packed as integer fields
    function automatic void model(input int addr, input bit ram_ok,
                                  output int eb, output int eg, output int er, output int ew);
        int lay, last, src, dv, slot, a, o;
        lay  = m_mode % 4;
        last = ((m_mode / 4) % 2 == 1) ? m_bank[3] : 255;
        a = outer_and; o = outer_or;
        eb = 0; eg = 2; er = 0; ew = 0;
        if (addr >= 'h8000) begin
            slot = (addr - 'h8000) / 'h2000;
            er = 1;
            if (lay == 0)      begin src = last; dv = 4; eg = 0; end
            else if (lay == 1) begin src = (slot < 2) ? m_bank[1] : last; dv = 2; eg = 1; end
            else               begin src = (slot < 3) ? m_bank[slot] : last; dv = 1; eg = 2; end
            if (lay == 3) src = flip(src);
            eb = (src & (a / dv)) | (o / dv);
        end else if (addr >= 'h6000) begin
            if (m_mode >= 128) begin
                er = 1;
                case (lay)
                    0: src = (m_bank[3] * 4 + 3) % 256;
                    1: src = (m_bank[3] * 2 + 1) % 256;
                    2: src = m_bank[3];
                    default: src = flip(m_bank[3]);
                endcase
                eb = (src & a) | o;
            end else begin
                ew = ram_ok ? 1 : 0;
            end
        end
    endfunction

    function automatic string tag_for(input int addr);
        if (addr < 'h6000) return "R10";
        if (addr < 'h8000) return (m_mode >= 128) ? "R8" : "R9";
        case (m_mode % 4)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic compare(input string tag);
        int eb, eg, er, ew;
        model(cpu_addr, 1'b1, eb, eg, er, ew);
        compared++;
        if (prg_bank !== eb[7:0] || prg_gran !== eg[1:0] || rom_sel !== er[0] || ram_sel !== ew[0]) begin
            mismatched++;
            $display("FAIL %s addr=%h mode=%h: got bank=%h gran=%0d rom=%0b ram=%0b exp bank=%h gran=%0d rom=%0d ram=%0d",
                     tag, cpu_addr, m_mode[7:0], prg_bank, prg_gran, rom_sel, ram_sel, eb[7:0], eg, er, ew);
        end
        model(cpu_addr, 1'b0, eb, eg, er, ew);
        compared++;
        if (nr_bank !== eb[7:0] || nr_rom !== er[0] || nr_ram !== ew[0]) begin
            mismatched++;
            $display("FAIL R9 no-RAM addr=%h: got bank=%h rom=%0b ram=%0b exp bank=%h rom=%0d ram=%0d",
                     cpu_addr, nr_bank, nr_rom, nr_ram, eb[7:0], er, ew);
        end
    endtask

    // One cycle: drive inputs after the falling edge, compare, then let the edge commit writes.
    task automatic cyc(input logic [15:0] addr, input bit bwe, input logic [1:0] bsel,
                       input logic [7:0] bdat, input bit mwe, input logic [7:0] mdat,
                       input string tag);
        @(negedge clk);
        cpu_addr = addr; bank_we = bwe; bank_sel = bsel; bank_wdata = bdat;
        mode_we = mwe; mode_wdata = mdat;
        #1;
        compare(tag == "" ? tag_for(addr) : tag);
        @(posedge clk);
        if (bwe) m_bank[bsel] = bdat;
        if (mwe) m_mode = mdat;
    endtask

    task automatic sweep();
        for (int r = 0; r < 8; r++)
            cyc(16'(r * 'h2000 + 'h0123 * r), 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, "");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] masks_and[3];
        logic [7:0] masks_or[3];
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
        m_mode = 0;
        masks_and = '{8'hFF, 8'h0F, 8'hF3};
        masks_or  = '{8'h00, 8'h30, 8'h04};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state across all regions
        for (int r = 0; r < 8; r++)
            cyc(16'(r * 'h2000 + 'h0040), 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, "R1");

        // R2: load bank registers
        cyc(16'h1000, 1'b1, 2'd0, 8'h35, 1'b0, 8'h00, "R2");
        cyc(16'h1000, 1'b1, 2'd1, 8'hA6, 1'b0, 8'h00, "R2");
        cyc(16'h1000, 1'b1, 2'd2, 8'h5C, 1'b0, 8'h00, "R2");
        cyc(16'h1000, 1'b1, 2'd3, 8'hC9, 1'b0, 8'h00, "R2");

        // R3..R8: every layout, fixed/register last bank, window ROM/RAM, three mask pairs
        for (int m = 0; m < 16; m++) begin
            logic [7:0] md;
            md = {m[3], 4'b0, m[2], m[1:0]};
            cyc(16'h2000, 1'b0, 2'd0, 8'h00, 1'b1, md, "R2");
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                outer_and = masks_and[k];
                outer_or  = masks_or[k];
                sweep();
            end
        end
        outer_and = 8'hFF; outer_or = 8'h00;

        // R11: write register 1 while reading 8000h in 16 KiB layout
        cyc(16'h8000, 1'b0, 2'd0, 8'h00, 1'b1, 8'h01, "R11");
        cyc(16'h8000, 1'b1, 2'd1, 8'h17, 1'b0, 8'h00, "R11");
        cyc(16'h8000, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, "R11");
        // R11/R3: mode and register 3 change on one edge while reading E000h
        cyc(16'hE000, 1'b1, 2'd3, 8'h4B, 1'b1, 8'h87, "R11");
        cyc(16'hE000, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, "R3");
        cyc(16'h6000, 1'b1, 2'd3, 8'h81, 1'b1, 8'h86, "R11");
        cyc(16'h6000, 1'b0, 2'd0, 8'h00, 1'b0, 8'h00, "R8");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (rv[3:0] == 0) begin
                @(negedge clk);
                outer_and = 8'($urandom);
                outer_or  = 8'($urandom);
            end
            cyc(16'($urandom), rv[4] & rv[5], rv[7:6], 8'($urandom),
                rv[8] & rv[9] & rv[10], 8'($urandom), "");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule